// File: doc/BRIEF.md
# Integer Decode and Address Generation Stage

This block is the decode stage of a 64-bit load/store processor with fixed 32-bit instruction words. Each cycle it can accept one instruction word, together with the address of that instruction and the two 64-bit values already read from the register file. It sorts the word into one of five format classes: privileged call, branch, memory, integer operate or floating operate. It pulls out the register specifiers and function codes, and picks the second operand. It also does the address arithmetic the stage owns: memory effective addresses (including the shifted "address high" form), branch targets and the return address.

Every result is held in one output register stage behind a valid/ready handshake. The register file, the execution units, the caches and exception handling sit around the block and are not part of it. A downstream execute stage takes the registered bundle when `outValid` is high and raises `outReady` when it can accept the next one.

Top module: `decode_agen`

## Requirements
- R1: After reset, `outValid`, `outWrEn` and `outAddr` are all zero.
- R2: The opcode is bits 31..26. `outFmt` encodes the class as follows: opcode 0x00 gives 0 (privileged call), 0x30–0x3F give 1 (branch), 0x08–0x0F, 0x18–0x1F and 0x20–0x2F give 2 (memory), 0x10–0x13 give 3 (integer operate) and 0x14–0x17 give 4 (floating operate). Opcodes 0x01–0x07 give 7 and set `outIllegal`, and such a word writes no register.
- R3: `outRa` is bits 25..21, `outRb` is bits 20..16 and `outRc` is bits 4..0. `outFunc` is bits 11..5, zero-extended, for integer operate, bits 15..5 for floating operate, and 0 otherwise. `outPalFunc` is bits 25..0 for a privileged call and 0 otherwise. `outOpA` is the first register value.
- R4: For integer operate with bit 12 = 1, `outOpB` is bits 20..13 zero-extended to 64 bits. In every other case `outOpB` is the second register value, and for integer operate bits 15..13 have no effect on it.
- R5: For memory format, `outAddr` is the second register value plus the sign-extended bits 15..0, taken modulo 2^64.
- R6: Opcode 0x09 uses the sign-extended displacement multiplied by 65536 in place of the plain displacement. Opcodes 0x08 and 0x09 write the result to Ra.
- R7: For branches, `outTarget` is PC+4 plus four times the sign-extended bits 20..0, and `outAddr` is PC+4, which is the return address.
- R8: `outWrEn` and `outDest` follow the class. Integer and floating operate write Rc. Memory words write Ra, except stores (0x0D–0x0F, and 0x20–0x2F with opcode bit 2 set). Branches 0x30 and 0x34 write Ra. Privileged calls write nothing. A destination of 31 always clears `outWrEn`.
- R9: `inReady` = !`outValid` || `outReady`. A word is captured on the clock edge where `inValid` and `inReady` are both high. On an edge where `inReady` is high and `inValid` is low, `outValid` drops. While `outValid` is high and `outReady` is low, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word is present |
| inReady | output | 1 | Stage can take a word this cycle |
| insn | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| rsA | input | 64 | Value read for the Ra field |
| rsB | input | 64 | Value read for the Rb field |
| outReady | input | 1 | Consumer accepts the registered bundle |
| outValid | output | 1 | Registered bundle is valid |
| outFmt | output | 3 | Format class code |
| outIllegal | output | 1 | Opcode is not assigned |
| outRa | output | 5 | Ra specifier |
| outRb | output | 5 | Rb specifier |
| outRc | output | 5 | Rc specifier |
| outOpA | output | 64 | First operand |
| outOpB | output | 64 | Second operand (register or literal) |
| outAddr | output | 64 | Effective address, or return address for branches |
| outTarget | output | 64 | Branch target |
| outWrEn | output | 1 | Destination register write enable |
| outDest | output | 5 | Destination register number |
| outFunc | output | 11 | Extended function code |
| outPalFunc | output | 26 | Privileged call number |

## Verification
A wrong class decision in the opcode decoder shows up one clock after capture as a wrong `outFmt`, together with a write enable or destination that does not match the class. A sign or scaling error in the adders shows up in `outAddr` or `outTarget` in that same cycle, and the wrap-around and negative-displacement cases make an extension error visible in the upper bits. A broken handshake register shows up in the cycle after a stall or a bubble: `outValid` stays high when it should drop, or the held outputs change while the consumer is stalled.

// File: rtl/decode_pkg.sv
package decode_pkg;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned FUNC_W = 11;
  localparam int unsigned PAL_W  = 26;

  typedef enum logic [2:0] {
    FMT_PAL    = 3'd0,
    FMT_BRANCH = 3'd1,
    FMT_MEM    = 3'd2,
    FMT_INTOP  = 3'd3,
    FMT_FPOP   = 3'd4,
    FMT_NONE   = 3'd7
  } fmt_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;
    logic isPal;
    logic isBranch;
    logic isMem;
    logic isIntOp;
    logic isFpOp;
    logic illegal;
    logic useLit;
    logic scaleHigh;
    logic wrRa;
    logic wrRc;
  } strobe_t;
endpackage

// File: rtl/decode_ctrl.sv
module decode_ctrl
  import decode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [OPC_W-1:0] opcode,
  input  logic             litSel,
  output logic             inReady,
  output logic             outValid,
  output strobe_t          strb,
  output fmt_e             fmt
);
  logic isStore;

  assign inReady = !outValid || outReady;

  always_comb begin
    isStore = ((opcode >= 6'h0D) && (opcode <= 6'h0F)) ||
              ((opcode[5:4] == 2'b10) && opcode[2]);
    strb = '0;
    fmt  = FMT_NONE;
    strb.load = inValid && inReady;
    if (opcode == 6'h00) begin
      strb.isPal = 1'b1;
      fmt        = FMT_PAL;
    end else if (opcode[5:2] == 4'b0100) begin
      strb.isIntOp = 1'b1;
      strb.useLit  = litSel;
      strb.wrRc    = 1'b1;
      fmt          = FMT_INTOP;
    end else if (opcode[5:2] == 4'b0101) begin
      strb.isFpOp = 1'b1;
      strb.wrRc   = 1'b1;
      fmt         = FMT_FPOP;
    end else if (opcode[5:4] == 2'b11) begin
      strb.isBranch = 1'b1;
      strb.wrRa     = (opcode == 6'h30) || (opcode == 6'h34);
      fmt           = FMT_BRANCH;
    end else if ((opcode[5:3] == 3'b001) || (opcode[5:3] == 3'b011) ||
                 (opcode[5:4] == 2'b10)) begin
      strb.isMem     = 1'b1;
      strb.scaleHigh = (opcode == 6'h09);
      strb.wrRa      = !isStore;
      fmt            = FMT_MEM;
    end else begin
      strb.illegal = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        outValid <= 1'b0;
    else if (inReady) outValid <= inValid;
  end

  // R2: exactly one class strobe per word
  a_r2_one_class: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.isPal, strb.isBranch, strb.isMem, strb.isIntOp,
                strb.isFpOp, strb.illegal}) == 1);

  // R2: an unassigned opcode requests no write
  a_r2_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strb.illegal |-> !(strb.wrRa || strb.wrRc));

  // R9: a bubble empties the output register
  a_r9_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> !outValid);

  // R9: a stalled bundle stays valid
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/decode_dpath.sv
module decode_dpath
  import decode_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  fmt_e              fmt,
  input  logic [31:0]       insn,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rsA,
  input  logic [XLEN-1:0]   rsB,
  output logic [2:0]        outFmt,
  output logic              outIllegal,
  output logic [REG_W-1:0]  outRa,
  output logic [REG_W-1:0]  outRb,
  output logic [REG_W-1:0]  outRc,
  output logic [XLEN-1:0]   outOpA,
  output logic [XLEN-1:0]   outOpB,
  output logic [XLEN-1:0]   outAddr,
  output logic [XLEN-1:0]   outTarget,
  output logic              outWrEn,
  output logic [REG_W-1:0]  outDest,
  output logic [FUNC_W-1:0] outFunc,
  output logic [PAL_W-1:0]  outPalFunc
);
  localparam int unsigned DISP_W = 16;
  localparam int unsigned BR_W   = 21;
  localparam int unsigned LIT_W  = 8;
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  logic [XLEN-1:0]   dispExt, dispUsed, memAddr, nextPc, brOff, brTarget, opB, addrSel;
  logic [REG_W-1:0]  dest;
  logic              wrEn;
  logic [FUNC_W-1:0] func;
  logic [PAL_W-1:0]  palNum;

  always_comb begin
    dispExt  = {{(XLEN-DISP_W){insn[DISP_W-1]}}, insn[DISP_W-1:0]};
    dispUsed = strb.scaleHigh ? (dispExt << 16) : dispExt;
    memAddr  = rsB + dispUsed;
    nextPc   = pc + {{(XLEN-3){1'b0}}, 3'd4};
    brOff    = {{(XLEN-BR_W-2){insn[BR_W-1]}}, insn[BR_W-1:0], 2'b00};
    brTarget = nextPc + brOff;
    opB      = strb.useLit ? {{(XLEN-LIT_W){1'b0}}, insn[20:13]} : rsB;
    if (strb.isBranch)   addrSel = nextPc;
    else if (strb.isMem) addrSel = memAddr;
    else                 addrSel = '0;
    if (strb.wrRc)      dest = insn[4:0];
    else if (strb.wrRa) dest = insn[25:21];
    else                dest = '0;
    wrEn = (strb.wrRa || strb.wrRc) && (dest != ZERO_REG);
    if (strb.isIntOp)     func = {4'b0000, insn[11:5]};
    else if (strb.isFpOp) func = insn[15:5];
    else                  func = '0;
    palNum = strb.isPal ? insn[25:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outFmt     <= '0;
      outIllegal <= 1'b0;
      outRa      <= '0;
      outRb      <= '0;
      outRc      <= '0;
      outOpA     <= '0;
      outOpB     <= '0;
      outAddr    <= '0;
      outTarget  <= '0;
      outWrEn    <= 1'b0;
      outDest    <= '0;
      outFunc    <= '0;
      outPalFunc <= '0;
    end else if (strb.load) begin
      outFmt     <= fmt;
      outIllegal <= strb.illegal;
      outRa      <= insn[25:21];
      outRb      <= insn[20:16];
      outRc      <= insn[4:0];
      outOpA     <= rsA;
      outOpB     <= opB;
      outAddr    <= addrSel;
      outTarget  <= strb.isBranch ? brTarget : '0;
      outWrEn    <= wrEn;
      outDest    <= dest;
      outFunc    <= func;
      outPalFunc <= palNum;
    end
  end

  // R8: the always-zero register is never written
  a_r8_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |-> (outDest != ZERO_REG));

  // R6: the scaled form leaves the low 16 bits of the base untouched
  a_r6_high_low: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.scaleHigh) |=> (outAddr[15:0] == $past(rsB[15:0])));

  // R7: an aligned PC gives an aligned target
  a_r7_align: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.isBranch && (pc[1:0] == 2'b00)) |=> (outTarget[1:0] == 2'b00));

  // R9: without a capture the bundle is frozen
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(outAddr) && $stable(outDest) && $stable(outOpB)));
endmodule

// File: rtl/decode_agen.sv
module decode_agen
  import decode_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [31:0]       insn,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rsA,
  input  logic [XLEN-1:0]   rsB,
  input  logic              outReady,
  output logic              outValid,
  output logic [2:0]        outFmt,
  output logic              outIllegal,
  output logic [REG_W-1:0]  outRa,
  output logic [REG_W-1:0]  outRb,
  output logic [REG_W-1:0]  outRc,
  output logic [XLEN-1:0]   outOpA,
  output logic [XLEN-1:0]   outOpB,
  output logic [XLEN-1:0]   outAddr,
  output logic [XLEN-1:0]   outTarget,
  output logic              outWrEn,
  output logic [REG_W-1:0]  outDest,
  output logic [FUNC_W-1:0] outFunc,
  output logic [PAL_W-1:0]  outPalFunc
);
  strobe_t strb;
  fmt_e    fmt;

  decode_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .opcode   (insn[31:26]),
    .litSel   (insn[12]),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb),
    .fmt      (fmt)
  );

  decode_dpath #(.XLEN(XLEN)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .fmt        (fmt),
    .insn       (insn),
    .pc         (pc),
    .rsA        (rsA),
    .rsB        (rsB),
    .outFmt     (outFmt),
    .outIllegal (outIllegal),
    .outRa      (outRa),
    .outRb      (outRb),
    .outRc      (outRc),
    .outOpA     (outOpA),
    .outOpB     (outOpB),
    .outAddr    (outAddr),
    .outTarget  (outTarget),
    .outWrEn    (outWrEn),
    .outDest    (outDest),
    .outFunc    (outFunc),
    .outPalFunc (outPalFunc)
  );
endmodule

// File: tb/sim_decode_agen.sv
`timescale 1ns/1ps
module sim_decode_agen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] pc = '0, rsA = '0, rsB = '0;
  logic        outReady = 1'b1;
  logic        inReady, outValid, outIllegal, outWrEn;
  logic [2:0]  outFmt;
  logic [4:0]  outRa, outRb, outRc, outDest;
  logic [63:0] outOpA, outOpB, outAddr, outTarget;
  logic [10:0] outFunc;
  logic [25:0] outPalFunc;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  decode_agen u0 (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] sx16(input logic [15:0] d);
    return {{48{d[15]}}, d};
  endfunction

  function automatic logic [31:0] mkMem(input logic [5:0] op, input logic [4:0] ra, input logic [4:0] rb, input logic [15:0] d);
    return {op, ra, rb, d};
  endfunction

  task automatic apply(input logic [31:0] w, input logic [63:0] p, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    insn = w; pc = p; rsA = a; rsB = b; inValid = 1'b1;
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 outValid", {63'd0, outValid}, 64'd0);
    chk("R1 outWrEn", {63'd0, outWrEn}, 64'd0);
    chk("R1 outAddr", outAddr, 64'd0);
  endtask

  task automatic t_int_reg;
    // op 0x10, Ra 3, Rb 4, sbz 101, bit12 0, func 0x20, Rc 5
    apply({6'h10, 5'd3, 5'd4, 3'b101, 1'b0, 7'h20, 5'd5}, 64'h100, 64'hA5, 64'h1234_5678_9ABC_DEF0);
    chk("R2 fmt intop", {61'd0, outFmt}, 64'd3);
    chk("R3 ra", {59'd0, outRa}, 64'd3);
    chk("R3 rb", {59'd0, outRb}, 64'd4);
    chk("R3 rc", {59'd0, outRc}, 64'd5);
    chk("R3 func7", {53'd0, outFunc}, 64'h20);
    chk("R3 opA", outOpA, 64'hA5);
    chk("R4 opB reg ignores sbz", outOpB, 64'h1234_5678_9ABC_DEF0);
    chk("R8 int writes rc", {58'd0, outWrEn, outDest}, {58'd0, 1'b1, 5'd5});
  endtask

  task automatic t_int_lit;
    apply({6'h11, 5'd1, 8'hC8, 1'b1, 7'h7F, 5'd7}, 64'h100, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R4 literal zero-extended", outOpB, 64'hC8);
    chk("R3 func7 lit", {53'd0, outFunc}, 64'h7F);
  endtask

  task automatic t_fp;
    apply({6'h16, 5'd2, 5'd3, 11'h5A3, 5'd9}, 64'h0, 64'h0, 64'h77);
    chk("R2 fmt fpop", {61'd0, outFmt}, 64'd4);
    chk("R3 func11", {53'd0, outFunc}, 64'h5A3);
    chk("R4 fp opB reg", outOpB, 64'h77);
    chk("R8 fp writes rc", {58'd0, outWrEn, outDest}, {58'd0, 1'b1, 5'd9});
  endtask

  task automatic t_mem;
    apply(mkMem(6'h29, 5'd2, 5'd6, 16'hFFF0), 64'h0, 64'h0, 64'h1000);
    chk("R2 fmt mem", {61'd0, outFmt}, 64'd2);
    chk("R5 negative disp", outAddr, 64'h1000 + sx16(16'hFFF0));
    chk("R8 load writes ra", {58'd0, outWrEn, outDest}, {58'd0, 1'b1, 5'd2});
    apply(mkMem(6'h28, 5'd2, 5'd6, 16'h0020), 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0);
    chk("R5 wrap", outAddr, 64'h10);
    apply(mkMem(6'h2D, 5'd4, 5'd6, 16'h0008), 64'h0, 64'h0, 64'h200);
    chk("R5 store addr", outAddr, 64'h208);
    chk("R8 store no write", {63'd0, outWrEn}, 64'd0);
  endtask

  task automatic t_lda;
    apply(mkMem(6'h08, 5'd10, 5'd1, 16'h7FFF), 64'h0, 64'h0, 64'h1);
    chk("R6 lda sum", outAddr, 64'h8000);
    chk("R6 lda writes ra", {58'd0, outWrEn, outDest}, {58'd0, 1'b1, 5'd10});
    apply(mkMem(6'h09, 5'd11, 5'd1, 16'h8001), 64'h0, 64'h0, 64'h10);
    chk("R6 ldah scaled", outAddr, 64'h10 + (sx16(16'h8001) << 16));
    chk("R6 ldah writes ra", {58'd0, outWrEn, outDest}, {58'd0, 1'b1, 5'd11});
  endtask

  task automatic t_branch;
    apply({6'h39, 5'd1, 21'h1FFFFD}, 64'h4000, 64'h0, 64'h0);
    chk("R2 fmt branch", {61'd0, outFmt}, 64'd1);
    chk("R7 backward target", outTarget, 64'h4004 - 64'd12);
    chk("R7 return addr", outAddr, 64'h4004);
    chk("R8 cond branch no write", {63'd0, outWrEn}, 64'd0);
    apply({6'h34, 5'd26, 21'h000100}, 64'h2000, 64'h0, 64'h0);
    chk("R7 forward target", outTarget, 64'h2404);
    chk("R8 call writes ra", {58'd0, outWrEn, outDest}, {58'd0, 1'b1, 5'd26});
  endtask

  task automatic t_pal_illegal;
    apply({6'h00, 26'h2ABCDEF}, 64'h0, 64'h0, 64'h0);
    chk("R2 fmt pal", {61'd0, outFmt}, 64'd0);
    chk("R3 pal number", {38'd0, outPalFunc}, 64'h2ABCDEF);
    chk("R8 pal no write", {63'd0, outWrEn}, 64'd0);
    apply({6'h05, 26'h3FFFFFF}, 64'h0, 64'h0, 64'h0);
    chk("R2 illegal flag", {63'd0, outIllegal}, 64'd1);
    chk("R2 illegal fmt", {61'd0, outFmt}, 64'd7);
    chk("R2 illegal no write", {63'd0, outWrEn}, 64'd0);
  endtask

  task automatic t_zero_reg;
    apply({6'h10, 5'd3, 5'd4, 3'b000, 1'b0, 7'h20, 5'd31}, 64'h0, 64'h0, 64'h0);
    chk("R8 rc 31 no write", {63'd0, outWrEn}, 64'd0);
    apply(mkMem(6'h08, 5'd31, 5'd1, 16'h0004), 64'h0, 64'h0, 64'h0);
    chk("R8 ra 31 no write", {63'd0, outWrEn}, 64'd0);
  endtask

  task automatic t_stall;
    apply(mkMem(6'h08, 5'd5, 5'd1, 16'h0100), 64'h0, 64'h0, 64'h0);
    outReady = 1'b0;
    @(negedge clk);
    insn = mkMem(6'h08, 5'd6, 5'd1, 16'h0200); rsB = 64'h0; inValid = 1'b1;
    #0.5;
    chk("R9 not ready while stalled", {63'd0, inReady}, 64'd0);
    @(posedge clk); #1;
    chk("R9 held valid", {63'd0, outValid}, 64'd1);
    chk("R9 held addr", outAddr, 64'h100);
    chk("R9 held dest", {59'd0, outDest}, 64'd5);
    outReady = 1'b1;
    @(posedge clk); #1;
    inValid = 1'b0;
    chk("R9 capture after release", outAddr, 64'h200);
    @(posedge clk); #1;
    chk("R9 bubble drops valid", {63'd0, outValid}, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rstN = 1'b1;
    t_int_reg();
    t_int_lit();
    t_fp();
    t_mem();
    t_lda();
    t_branch();
    t_pal_illegal();
    t_zero_reg();
    t_stall();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule